// File: doc/BRIEF.md
# Serial NOR Flash Byte-Access Controller

This block lets a host run single-byte operations on a serial NOR flash through a small bank of byte registers. The host writes a 24-bit flash address, and then writes a command register. The trigger bit it sets picks one of five jobs: fetch a byte, fetch the flash status byte, send an arbitrary bit string taken from a program-data bank, program a byte, or write the flash status byte. The controller builds the serial frames, drives a mode-0 SPI link (SCK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, most significant bit first) and stores what comes back.

The trigger bit that started a job stays readable as 1 until the job ends. Software polls the command register until it reads 0, then reads the result. An auto-increment bit moves the address on after each byte read or byte write, so software can stream through a range. Triggers only work after the unlock key 0x30 has been written.

Sequencer states: `SQ_IDLE` (waiting), `SQ_READ` (opcode 0x03 frame), `SQ_STAT` (0x05 frame), `SQ_PROG` (bank frame), `SQ_WEN_BYTE` and `SQ_WEN_STAT` (0x06 write-enable frame ahead of a write), `SQ_PAGE` (0x02 frame) and `SQ_WSTAT` (0x01 frame). Transitions:
- `SQ_IDLE` goes to the state of the accepted trigger.
- `SQ_WEN_BYTE` goes to `SQ_PAGE`, and `SQ_WEN_STAT` goes to `SQ_WSTAT`, when the engine reports its frame done.
- Every other state returns to `SQ_IDLE` on frame done.

Engine states:
- `EN_IDLE` goes to `EN_LOW` on start.
- `EN_LOW` goes to `EN_HIGH` after half an SCK period.
- `EN_HIGH` goes back to `EN_LOW`, or to `EN_GAP` after the last bit.
- `EN_GAP` goes to `EN_IDLE` after two SCK periods with CS_n high.

Top module: `nor_pio_ctrl`

## Requirements
- R1: After reset, every host register reads 0, cs_n is 1, sck is 0 and the controller is locked.
- R2: The link runs in SPI mode 0, MSB first. SCK high and low phases each last CLK_DIV/2 clock cycles. cs_n stays high for at least 2*CLK_DIV clock cycles between frames.
- R3: Command bit 0 sends opcode 0x03 followed by the 24-bit address (a 40-bit frame), and the last 8 MISO bits land in the read-data register at offset 3.
- R4: If command bit 7 is set together with a byte read or byte write, the address advances by one, wrapping at 24 bits, when the job ends. Otherwise the address stays unchanged.
- R5: Command bit 1 sends opcode 0x05 (a 16-bit frame), and the returned byte lands in the status register at offset 2. Bit 0 of that byte is write-in-progress.
- R6: Command bit 2 sends the number of bits held at offset 1, taken from the bank at offsets 16 to 21, starting with offset 21 and MSB first. Counts above 48 are sent as 48, and a count of 0 starts no frame. The last 8 MISO bits land at offset 14.
- R7: Command bit 4 sends a 0x06 frame, then a 40-bit frame made of 0x02, the address and the write-data byte (offset 7).
- R8: Command bit 5 sends a 0x06 frame, then a 16-bit frame made of 0x01 and the write-data byte.
- R9: While a job runs, the command register reads back its trigger bit, plus bit 7 if it was written. When idle, the command register reads 0.
- R10: Writing 0x30 to offset 15 unlocks the controller, and offset 15 then reads 0x30. Any other value relocks it. Triggers written while locked start nothing.
- R11: When several trigger bits are written at once, only the lowest-numbered one runs. A command write made while a job runs is ignored.
- R12: The address is held as high, middle and low bytes at offsets 4, 5 and 6, each readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 5 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| sck | output | 1 | Serial clock to flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench builds the controller with CLK_DIV = 2, the fastest divider. This setting gives each SCK phase a single clock cycle, so every MISO bit must be sampled in the cycle right after the flash model drives it, and the frame gap sits at its minimum of four cycles. PRG_BYTES stays at 6. A 48-bit bank is therefore available: the check that clamps a count of 60 relies on it, and so does the check that a 40-bit read frame fits in the same shifter. A flash model in the bench decodes each frame and executes write enable, page program, sector erase and status write.

// File: rtl/nor_pio_pkg.sv
package nor_pio_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_READ, SQ_STAT, SQ_PROG,
        SQ_WEN_BYTE, SQ_WEN_STAT, SQ_PAGE, SQ_WSTAT
    } seq_state_t;

    typedef enum logic [1:0] {EN_IDLE, EN_LOW, EN_HIGH, EN_GAP} eng_state_t;

    localparam logic [4:0] OFS_CMD  = 5'd0;
    localparam logic [4:0] OFS_BITS = 5'd1;
    localparam logic [4:0] OFS_STAT = 5'd2;
    localparam logic [4:0] OFS_RDAT = 5'd3;
    localparam logic [4:0] OFS_AH   = 5'd4;
    localparam logic [4:0] OFS_AM   = 5'd5;
    localparam logic [4:0] OFS_AL   = 5'd6;
    localparam logic [4:0] OFS_WDAT = 5'd7;
    localparam logic [4:0] OFS_CAPT = 5'd14;
    localparam logic [4:0] OFS_LOCK = 5'd15;
    localparam logic [4:0] OFS_PRG  = 5'd16;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PAGE = 8'h02;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] UNLOCK_KEY = 8'h30;

    localparam int TRG_RD = 0;
    localparam int TRG_ST = 1;
    localparam int TRG_PG = 2;
    localparam int TRG_WB = 4;
    localparam int TRG_WS = 5;
    localparam int BIT_AINC = 7;
    localparam logic [7:0] TRIG_MASK = 8'h37;

endpackage

// File: rtl/nor_trig_pick.sv
module nor_trig_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] grant_o
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_pick
            assign grant_o[i]  = req_i[i] & ~seen[i];
            assign seen[i + 1] = seen[i] | req_i[i];
        end
    endgenerate
endmodule

// File: rtl/nor_frame_engine.sv
module nor_frame_engine
    import nor_pio_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int FRAME_W = 48,
    parameter int NB_W    = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [NB_W-1:0]    nbits_i,
    output logic               done_o,
    output logic [7:0]         rx_o,
    output logic               sck_o,
    output logic               cs_n_o,
    output logic               mosi_o,
    input  logic               miso_i
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int GAP  = 4 * HALF;
    localparam int HC_W = $clog2(GAP + 1);

    eng_state_t state_q, state_d;
    logic [HC_W-1:0]    hc_q;
    logic [FRAME_W-1:0] tx_q;
    logic [NB_W-1:0]    nb_q, bit_q;
    logic [7:0]         rx_q;
    logic               sck_q, cs_n_q, done_q;

    wire half_end = (hc_q == HC_W'(HALF - 1));
    wire gap_end  = (hc_q == HC_W'(GAP - 1));
    wire last_bit = (bit_q == nb_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_IDLE: if (start_i)  state_d = EN_LOW;
            EN_LOW:  if (half_end) state_d = EN_HIGH;
            EN_HIGH: if (half_end) state_d = last_bit ? EN_GAP : EN_LOW;
            EN_GAP:  if (gap_end)  state_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q <= '0; tx_q <= '0; nb_q <= '0; bit_q <= '0; rx_q <= '0;
            sck_q <= 1'b0; cs_n_q <= 1'b1; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                EN_IDLE: if (start_i) begin
                    cs_n_q <= 1'b0;
                    tx_q   <= frame_i;
                    nb_q   <= nbits_i;
                    bit_q  <= '0;
                    hc_q   <= '0;
                end
                EN_LOW: if (half_end) begin
                    hc_q  <= '0;
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso_i};
                end else hc_q <= hc_q + 1'b1;
                EN_HIGH: if (half_end) begin
                    hc_q  <= '0;
                    sck_q <= 1'b0;
                    tx_q  <= tx_q << 1;
                    bit_q <= bit_q + 1'b1;
                    if (last_bit) cs_n_q <= 1'b1;
                end else hc_q <= hc_q + 1'b1;
                EN_GAP: if (gap_end) begin
                    hc_q   <= '0;
                    done_q <= 1'b1;
                end else hc_q <= hc_q + 1'b1;
            endcase
        end
    end

    assign done_o = done_q;
    assign rx_o   = rx_q;
    assign sck_o  = sck_q;
    assign cs_n_o = cs_n_q;
    assign mosi_o = tx_q[FRAME_W-1];

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sck_q); // R2
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_q && $past(!cs_n_q) && !$fell(sck_q)) |-> $stable(mosi_o)); // R2
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == EN_IDLE)); // R11
endmodule

// File: rtl/nor_pio_ctrl.sv
module nor_pio_ctrl
    import nor_pio_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int PRG_BYTES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    input  logic       miso
);
    localparam int ADDR_W  = 24;
    localparam int FRAME_W = 8 * PRG_BYTES;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int PAD_RD  = FRAME_W - 8 - ADDR_W;
    localparam int PAD_PG  = FRAME_W - 16 - ADDR_W;
    localparam int PAD_SR  = FRAME_W - 16;

    seq_state_t seq_q, seq_d;
    logic [7:0]        busy_q, grant, bits_q, stat_q, rdat_q, wdat_q, capt_q;
    logic              ainc_q, unlk_q, start_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        prg_q [PRG_BYTES];
    logic [FRAME_W-1:0] frame;
    logic [NB_W-1:0]   nbits;
    logic              eng_done;
    logic [7:0]        eng_rx;

    nor_trig_pick #(.W(8)) u_pick (
        .req_i  (reg_wdata & TRIG_MASK),
        .grant_o(grant)
    );

    wire cmd_wr  = reg_wr && (reg_addr == OFS_CMD);
    wire accept  = cmd_wr && unlk_q && (seq_q == SQ_IDLE) && (|grant)
                   && !(grant[TRG_PG] && (bits_q == 8'd0));
    wire wen_end = eng_done && (seq_q == SQ_WEN_BYTE || seq_q == SQ_WEN_STAT);
    wire job_end = eng_done && !wen_end;
    wire addr_wr = reg_wr && (reg_addr == OFS_AH || reg_addr == OFS_AM || reg_addr == OFS_AL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SQ_IDLE: if (accept) begin
                if (grant[TRG_RD])      seq_d = SQ_READ;
                else if (grant[TRG_ST]) seq_d = SQ_STAT;
                else if (grant[TRG_PG]) seq_d = SQ_PROG;
                else if (grant[TRG_WB]) seq_d = SQ_WEN_BYTE;
                else                    seq_d = SQ_WEN_STAT;
            end
            SQ_WEN_BYTE: if (eng_done) seq_d = SQ_PAGE;
            SQ_WEN_STAT: if (eng_done) seq_d = SQ_WSTAT;
            SQ_READ, SQ_STAT, SQ_PROG, SQ_PAGE, SQ_WSTAT:
                if (eng_done) seq_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        frame = '0;
        nbits = '0;
        unique case (seq_q)
            SQ_READ: begin
                frame = {OP_READ, addr_q, {PAD_RD{1'b0}}};
                nbits = NB_W'(40);
            end
            SQ_STAT: begin
                frame = {OP_RDSR, {(FRAME_W - 8){1'b0}}};
                nbits = NB_W'(16);
            end
            SQ_PROG: begin
                for (int i = 0; i < PRG_BYTES; i++) frame[8*i +: 8] = prg_q[i];
                nbits = (bits_q > 8'(FRAME_W)) ? NB_W'(FRAME_W) : NB_W'(bits_q);
            end
            SQ_WEN_BYTE, SQ_WEN_STAT: begin
                frame = {OP_WREN, {(FRAME_W - 8){1'b0}}};
                nbits = NB_W'(8);
            end
            SQ_PAGE: begin
                frame = {OP_PAGE, addr_q, wdat_q, {PAD_PG{1'b0}}};
                nbits = NB_W'(40);
            end
            SQ_WSTAT: begin
                frame = {OP_WRSR, wdat_q, {PAD_SR{1'b0}}};
                nbits = NB_W'(16);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0; ainc_q <= 1'b0; unlk_q <= 1'b0; start_q <= 1'b0;
            bits_q <= '0; stat_q <= '0; rdat_q <= '0; wdat_q <= '0;
            capt_q <= '0; addr_q <= '0;
            for (int i = 0; i < PRG_BYTES; i++) prg_q[i] <= '0;
        end else begin
            start_q <= accept || wen_end;
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_BITS: bits_q <= reg_wdata;
                    OFS_AH:   addr_q[23:16] <= reg_wdata;
                    OFS_AM:   addr_q[15:8]  <= reg_wdata;
                    OFS_AL:   addr_q[7:0]   <= reg_wdata;
                    OFS_WDAT: wdat_q <= reg_wdata;
                    OFS_LOCK: unlk_q <= (reg_wdata == UNLOCK_KEY);
                    default: ;
                endcase
                for (int i = 0; i < PRG_BYTES; i++)
                    if (reg_addr == OFS_PRG + 5'(i)) prg_q[i] <= reg_wdata;
            end
            if (accept) begin
                busy_q <= grant;
                ainc_q <= reg_wdata[BIT_AINC];
            end
            if (job_end) begin
                busy_q <= '0;
                ainc_q <= 1'b0;
                if (seq_q == SQ_READ) rdat_q <= eng_rx;
                if (seq_q == SQ_STAT) stat_q <= eng_rx;
                if (seq_q == SQ_PROG) capt_q <= eng_rx;
                if (ainc_q && (seq_q == SQ_READ || seq_q == SQ_PAGE))
                    addr_q <= addr_q + 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = busy_q | {ainc_q, 7'b0};
            OFS_BITS: reg_rdata = bits_q;
            OFS_STAT: reg_rdata = stat_q;
            OFS_RDAT: reg_rdata = rdat_q;
            OFS_AH:   reg_rdata = addr_q[23:16];
            OFS_AM:   reg_rdata = addr_q[15:8];
            OFS_AL:   reg_rdata = addr_q[7:0];
            OFS_WDAT: reg_rdata = wdat_q;
            OFS_CAPT: reg_rdata = capt_q;
            OFS_LOCK: reg_rdata = unlk_q ? UNLOCK_KEY : 8'h00;
            default: ;
        endcase
        for (int i = 0; i < PRG_BYTES; i++)
            if (reg_addr == OFS_PRG + 5'(i)) reg_rdata = prg_q[i];
    end

    nor_frame_engine #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_q),
        .frame_i(frame),
        .nbits_i(nbits),
        .done_o (eng_done),
        .rx_o   (eng_rx),
        .sck_o  (sck),
        .cs_n_o (cs_n),
        .mosi_o (mosi),
        .miso_i (miso)
    );

    AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q)); // R11
    AST_LOCKED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlk_q && seq_q == SQ_IDLE) |=> (seq_q == SQ_IDLE)); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && !eng_done) |=> $stable(addr_q)); // R4
    AST_BUSY_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q != SQ_IDLE) |-> (busy_q != 8'd0)); // R9
endmodule

// File: tb/nor_pio_ctrl_tb_top.sv
module nor_pio_ctrl_tb_top;
    localparam int DIV = 2;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, miso = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic sck, cs_n, mosi;

    always #10 clk = ~clk;

    nor_pio_ctrl #(.CLK_DIV(DIV), .PRG_BYTES(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;

    // flash model and link monitor
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    logic [7:0] sr = 8'h00, op = 8'h00, last_op = 8'h00;
    logic [63:0] sh = '0;
    logic [23:0] maddr = '0;
    logic wel = 1'b0, psck = 1'b0, pcs = 1'b1;
    int nb = 0, wip = 0, frames = 0, last_nb = 0, hi_run = 0, gap = 1000, terr = 0;

    function automatic logic [7:0] init_val(int i);
        return 8'(i) ^ 8'h3C;
    endfunction
    function automatic int exp_bits(int c);
        return (c > 48) ? 48 : c;
    endfunction
    function automatic logic [23:0] addr_after(logic [23:0] a, int n);
        return a + 24'(n);
    endfunction

    initial for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); shadow[i] = init_val(i); end

    always @(negedge clk) begin
        logic [7:0] st;
        st = {sr[7:2], wel, (wip != 0)};
        if (sck) hi_run++;
        else if (psck) begin if (hi_run != DIV / 2) terr++; hi_run = 0; end
        if (cs_n) gap++;
        if (!cs_n && pcs) begin
            if (frames > 0 && gap < 2 * DIV) terr++;
            gap = 0; nb = 0; sh = '0; op = 8'h00;
        end
        if (!cs_n && sck && !psck) begin
            sh = {sh[62:0], mosi}; nb++;
            if (nb == 8)  op = sh[7:0];
            if (nb == 32) maddr = sh[23:0];
        end
        if (!cs_n && !sck && psck) begin
            if (op == 8'h03 && nb >= 32 && nb < 40) miso <= mem[maddr[7:0]][39 - nb];
            if (op == 8'h05 && nb >= 8 && nb < 16)  miso <= st[15 - nb];
            if (op == 8'h9F && nb >= 8 && nb < 16)  miso <= 8'h5A >> (15 - nb);
        end
        if (cs_n && !pcs) begin
            frames++; last_nb = nb; last_op = op;
            if (op == 8'h06 && nb == 8) wel = 1'b1;
            else if (op == 8'h02 && nb == 40 && wel) begin mem[sh[15:8]] = sh[7:0]; wel = 1'b0; wip = 2; end
            else if (op == 8'h20 && nb == 32 && wel) begin
                for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                wel = 1'b0; wip = 2;
            end
            else if (op == 8'h01 && nb == 16 && wel) begin sr = sh[7:0] & 8'hFC; wel = 1'b0; wip = 2; end
            else if (op == 8'h05 && wip > 0) wip--;
        end
        psck = sck; pcs = cs_n;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask
    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic rd(logic [4:0] a, output logic [7:0] v);
        reg_addr = a; #1 v = reg_rdata;
    endtask
    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); rd(5'd0, v);
            if (v == 8'h00) return;
        end
        check("R9 timeout", 32'd1, 32'd0);
    endtask
    task automatic set_addr(logic [23:0] a);
        wr(5'd4, a[23:16]); wr(5'd5, a[15:8]); wr(5'd6, a[7:0]);
    endtask
    task automatic get_addr(output logic [23:0] a);
        logic [7:0] h, m, l;
        rd(5'd4, h); rd(5'd5, m); rd(5'd6, l); a = {h, m, l};
    endtask
    task automatic poll_wip();
        logic [7:0] v;
        for (int i = 0; i < 20; i++) begin
            wr(5'd0, 8'h02); wait_idle(); rd(5'd2, v);
            if (!v[0]) return;
        end
        check("R5 wip never cleared", 32'd1, 32'd0);
    endtask

    initial begin
        logic [7:0] v;
        logic [23:0] a, base;
        int f0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(5'd0, v);  check("R1 cmd", v, 8'h00);
        rd(5'd15, v); check("R1 lock", v, 8'h00);
        rd(5'd3, v);  check("R1 rdata", v, 8'h00);
        check("R1 cs_n", cs_n, 1'b1);
        check("R1 sck", sck, 1'b0);
        // R10 lock
        wr(5'd0, 8'h01); repeat (20) @(negedge clk);
        rd(5'd0, v); check("R10 locked cmd", v, 8'h00);
        check("R10 locked frames", frames, 0);
        wr(5'd15, 8'h31); rd(5'd15, v); check("R10 wrong key", v, 8'h00);
        wr(5'd0, 8'h01); repeat (20) @(negedge clk);
        check("R10 wrong key frames", frames, 0);
        wr(5'd15, 8'h30); rd(5'd15, v); check("R10 unlocked", v, 8'h30);
        // R12 address bytes
        set_addr(24'h123456);
        rd(5'd4, v); check("R12 high", v, 8'h12);
        rd(5'd5, v); check("R12 mid", v, 8'h34);
        rd(5'd6, v); check("R12 low", v, 8'h56);
        // R9 busy readback, R3 read, R4 increment
        wr(5'd0, 8'h81); rd(5'd0, v); check("R9 busy", v, 8'h81);
        wait_idle();
        rd(5'd3, v); check("R3 data", v, shadow[8'h56]);
        check("R3 opcode", last_op, 8'h03); check("R3 bits", last_nb, 40);
        get_addr(a); check("R4 inc", a, addr_after(24'h123456, 1));
        wr(5'd0, 8'h01); wait_idle();
        get_addr(a); check("R4 no inc", a, 24'h123457);
        // R7 / R3 / R4 random writes and read-back
        for (int k = 0; k < 6; k++) begin
            base = 24'($urandom);
            set_addr(base);
            for (int i = 0; i < 3; i++) begin
                v = 8'($urandom);
                shadow[8'(base + 24'(i))] = v;
                wr(5'd7, v); wr(5'd0, 8'h90); wait_idle(); poll_wip();
            end
            get_addr(a); check("R4 after writes", a, addr_after(base, 3));
            set_addr(base);
            for (int i = 0; i < 3; i++) begin
                wr(5'd0, 8'h81); wait_idle(); rd(5'd3, v);
                check("R7 readback", v, shadow[8'(base + 24'(i))]);
            end
        end
        // R4 wrap
        set_addr(24'hFFFFFF); wr(5'd0, 8'h81); wait_idle();
        get_addr(a); check("R4 wrap", a, 24'h000000);
        rd(5'd3, v); check("R3 top byte", v, shadow[8'hFF]);
        // R11 priority and busy-ignore
        f0 = frames;
        wr(5'd0, 8'h33); rd(5'd0, v); check("R11 lowest wins", v, 8'h01);
        wr(5'd0, 8'h02); wait_idle();
        check("R11 one frame", frames - f0, 1);
        check("R11 opcode", last_op, 8'h03);
        // R8 status write, R5 status read
        wr(5'd7, 8'hA5); wr(5'd0, 8'h20); wait_idle(); poll_wip();
        wr(5'd0, 8'h02); wait_idle(); rd(5'd2, v);
        check("R8 status", v, 8'hA4);
        check("R5 opcode", last_op, 8'h05);
        // R6 generic command with capture
        wr(5'd1, 8'd16); wr(5'd21, 8'h9F); wr(5'd20, 8'h00);
        wr(5'd0, 8'h04); wait_idle();
        rd(5'd14, v); check("R6 capture", v, 8'h5A);
        check("R6 bits", last_nb, exp_bits(16)); check("R6 opcode", last_op, 8'h9F);
        wr(5'd1, 8'd8); wr(5'd21, 8'h06); wr(5'd0, 8'h04); wait_idle();
        wr(5'd1, 8'd32); wr(5'd21, 8'h20); wr(5'd20, 8'h00); wr(5'd19, 8'h00); wr(5'd18, 8'h00);
        wr(5'd0, 8'h04); wait_idle(); poll_wip();
        for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
        set_addr(24'h000042); wr(5'd0, 8'h01); wait_idle();
        rd(5'd3, v); check("R6 erase", v, shadow[8'h42]);
        wr(5'd1, 8'd60); wr(5'd21, 8'h9F); wr(5'd0, 8'h04); wait_idle();
        check("R6 clamp", last_nb, exp_bits(60));
        f0 = frames;
        wr(5'd1, 8'd0); wr(5'd0, 8'h04); repeat (20) @(negedge clk);
        check("R6 zero count", frames - f0, 0);
        rd(5'd0, v); check("R6 zero idle", v, 8'h00);
        // R2 timing
        check("R2 timing errors", terr, 0);
        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule